// File: doc/BRIEF.md
# Decode-Error Terminating Subordinate

This block sits on the AXI port that a bus splitter uses for every address no real subordinate decodes. It answers every request it is given, so a stray access can never hang the interconnect. A read comes back with as many beats as the request's length field asks for. Each beat has zero data and the decode-error response, and the last-beat flag is set on the final beat only. A write has all its data beats taken in and then receives one decode-error response. No storage is kept and no address is examined, so the address and write-data payload are not brought into the block.

All five channels use valid/ready handshakes. A transfer happens on a rising clock edge where both are high. Once the block raises a valid on R or B, it keeps that valid and its payload unchanged until ready is seen, so the manager may stall either channel for as long as it likes. The read side serves one burst at a time, and so does the write side. While a transaction is open, the matching address ready is low, which pushes back on the next request. The two sides are fully independent. Built with `LITE` set, the block serves a lite bus, where each read is a single beat.

Top module: `dec_err_target`

## Requirements
- R1: Out of reset `s_arready`, `s_awready` and `s_wready` are 1 and `s_rvalid`, `s_bvalid` are 0. `s_arready` falls after an AR handshake and stays 0 until the edge that accepts that burst's final R beat.
- R2: Each accepted read with length field L yields exactly L+1 R beats, and `s_rlast` is 1 on the last of them and on no other.
- R3: Every R beat has `s_rdata` all zero, `s_rresp` = 2'b11 (decode error) and `s_rid` equal to the ARID of its request.
- R4: While `s_rvalid` is 1 and `s_rready` is 0, `s_rvalid`, `s_rid`, `s_rlast`, `s_rdata` and `s_rresp` hold their values into the next cycle.
- R5: With `LITE` = 1, every read yields one beat with `s_rlast` = 1, whatever `s_arlen` carries.
- R6: `s_wready` is 1 until the beat carrying `s_wlast` is accepted, and W beats are taken whether or not the burst's AW has arrived.
- R7: One B beat is issued per write, once both its AW and its WLAST beat have been accepted. It carries `s_bresp` = 2'b11 and `s_bid` equal to that AWID, and it appears in the cycle after the later of the two handshakes.
- R8: While `s_bvalid` is 1 and `s_bready` is 0, `s_bvalid` and `s_bid` hold. `s_awready` is 0 from an AW handshake, and `s_wready` is 0 from a WLAST handshake, until the B handshake.
- R9: A read burst and a write may finish on the same clock edge without either delaying the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_arvalid | input | 1 | Read request valid |
| s_arready | output | 1 | Read request accepted |
| s_arid | input | ID_W | Read transaction ID |
| s_arlen | input | LEN_W | Read beats minus one (ignored when LITE) |
| s_rvalid | output | 1 | Read beat valid |
| s_rready | input | 1 | Read beat taken |
| s_rid | output | ID_W | Read beat ID |
| s_rdata | output | DATA_W | Read data, always zero |
| s_rresp | output | 2 | Read response, always 2'b11 |
| s_rlast | output | 1 | Final beat of burst |
| s_awvalid | input | 1 | Write request valid |
| s_awready | output | 1 | Write request accepted |
| s_awid | input | ID_W | Write transaction ID |
| s_wvalid | input | 1 | Write beat valid |
| s_wready | output | 1 | Write beat accepted |
| s_wlast | input | 1 | Final write beat |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_bid | output | ID_W | Write response ID |
| s_bresp | output | 2 | Write response, always 2'b11 |

## Verification
The final R beat of a burst and the B handshake can land on the same clock edge. Each one frees its own address channel on that edge. The bench runs read and write traffic at once, with random lengths and with phases of free, random and heavy back-pressure on R and B. This makes the two completions collide often. A queue-based model is compared with every output on every cycle, so a collision that stalls, drops or merges either completion shows up at once. The bench also counts how many collisions occurred and requires at least one.

// File: rtl/dec_err_pkg.sv
`timescale 1ns/1ps
package dec_err_pkg;
  localparam logic [1:0] RESP_DECERR = 2'b11;
  typedef enum logic {RD_IDLE, RD_BURST} rd_state_e;
endpackage

// File: rtl/dec_err_rd.sv
`timescale 1ns/1ps
module dec_err_rd import dec_err_pkg::*; #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter bit LITE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ID_W-1:0]   arid,
  input  logic [LEN_W-1:0]  arlen,
  output logic              rvalid,
  input  logic              rready,
  output logic [ID_W-1:0]   rid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rlast
);
  rd_state_e        state_q;
  logic [LEN_W-1:0] left_q;
  logic [ID_W-1:0]  id_q;
  logic [LEN_W-1:0] eff_len;
  logic             ar_hs, r_hs;

  // Lite bus: length field carries no meaning, every burst is one beat.
  generate
    if (LITE) begin : g_lite
      assign eff_len = '0;
    end else begin : g_full
      assign eff_len = arlen;
    end
  endgenerate

  assign arready = (state_q == RD_IDLE);
  assign rvalid  = (state_q == RD_BURST);
  assign ar_hs   = arvalid && arready;
  assign r_hs    = rvalid && rready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RD_IDLE;
      left_q  <= '0;
      id_q    <= '0;
    end else begin
      if (ar_hs) begin
        state_q <= RD_BURST;
        left_q  <= eff_len;
        id_q    <= arid;
      end else if (r_hs) begin
        if (left_q == '0) state_q <= RD_IDLE;
        else              left_q  <= left_q - 1'b1;
      end
    end
  end

  assign rid   = id_q;
  assign rdata = '0;
  assign rresp = RESP_DECERR;
  assign rlast = rvalid && (left_q == '0);
endmodule

// File: rtl/dec_err_wr.sv
`timescale 1ns/1ps
module dec_err_wr import dec_err_pkg::*; #(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            awvalid,
  output logic            awready,
  input  logic [ID_W-1:0] awid,
  input  logic            wvalid,
  output logic            wready,
  input  logic            wlast,
  output logic            bvalid,
  input  logic            bready,
  output logic [ID_W-1:0] bid,
  output logic [1:0]      bresp
);
  logic            aw_held_q;
  logic            wl_held_q;
  logic [ID_W-1:0] id_q;
  logic            aw_hs, wl_hs, b_hs;

  assign awready = !aw_held_q;
  assign wready  = !wl_held_q;
  assign bvalid  = aw_held_q && wl_held_q;
  assign aw_hs   = awvalid && awready;
  assign wl_hs   = wvalid && wready && wlast;
  assign b_hs    = bvalid && bready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held_q <= 1'b0;
      wl_held_q <= 1'b0;
      id_q      <= '0;
    end else if (b_hs) begin
      aw_held_q <= 1'b0;
      wl_held_q <= 1'b0;
    end else begin
      if (aw_hs) begin
        aw_held_q <= 1'b1;
        id_q      <= awid;
      end
      if (wl_hs) wl_held_q <= 1'b1;
    end
  end

  assign bid   = id_q;
  assign bresp = RESP_DECERR;
endmodule

// File: rtl/dec_err_target.sv
`timescale 1ns/1ps
module dec_err_target #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter bit LITE   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ID_W-1:0]   s_arid,
  input  logic [LEN_W-1:0]  s_arlen,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ID_W-1:0]   s_rid,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [ID_W-1:0]   s_awid,
  input  logic              s_wvalid,
  output logic              s_wready,
  input  logic              s_wlast,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [ID_W-1:0]   s_bid,
  output logic [1:0]        s_bresp
);
  dec_err_rd #(.ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .LITE(LITE)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .arvalid(s_arvalid), .arready(s_arready), .arid(s_arid), .arlen(s_arlen),
    .rvalid(s_rvalid), .rready(s_rready), .rid(s_rid), .rdata(s_rdata),
    .rresp(s_rresp), .rlast(s_rlast)
  );

  dec_err_wr #(.ID_W(ID_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .awvalid(s_awvalid), .awready(s_awready), .awid(s_awid),
    .wvalid(s_wvalid), .wready(s_wready), .wlast(s_wlast),
    .bvalid(s_bvalid), .bready(s_bready), .bid(s_bid), .bresp(s_bresp)
  );
endmodule

// File: rtl/dec_err_target_sva.sv
`timescale 1ns/1ps
module dec_err_target_sva #(
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter bit LITE   = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [LEN_W-1:0]  s_arlen,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [ID_W-1:0]   s_rid,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rlast,
  input logic              s_awvalid,
  input logic              s_awready,
  input logic              s_wvalid,
  input logic              s_wready,
  input logic              s_wlast,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ID_W-1:0]   s_bid
);
  logic [LEN_W-1:0] beats_left;
  logic             saw_aw, saw_wl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beats_left <= '0;
      saw_aw     <= 1'b0;
      saw_wl     <= 1'b0;
    end else begin
      if (s_arvalid && s_arready)      beats_left <= LITE ? '0 : s_arlen;
      else if (s_rvalid && s_rready && beats_left != '0) beats_left <= beats_left - 1'b1;
      if (s_bvalid && s_bready) begin
        saw_aw <= 1'b0;
        saw_wl <= 1'b0;
      end else begin
        if (s_awvalid && s_awready)          saw_aw <= 1'b1;
        if (s_wvalid && s_wready && s_wlast) saw_wl <= 1'b1;
      end
    end
  end

  assert_one_read_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> !s_arready);
  assert_rlast_position_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && s_rready) |-> (s_rlast == (beats_left == '0)));
  assert_r_payload_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rid) && $stable(s_rlast)
                                  && $stable(s_rdata) && $stable(s_rresp)));
  assert_b_after_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_bvalid) |-> (saw_aw && saw_wl));
  assert_b_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid)));
  assert_aw_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid |-> (!s_awready && !s_wready));
endmodule

bind dec_err_target dec_err_target_sva #(
  .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .LITE(LITE)
) u_sva (
  .clk(clk), .rst_n(rst_n),
  .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arlen(s_arlen),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata),
  .s_rresp(s_rresp), .s_rlast(s_rlast),
  .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wlast(s_wlast),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid)
);

// File: tb/dec_err_target_tb.sv
`timescale 1ns/1ps
module dec_err_target_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0;

  logic        arvalid = 0, rready = 0, awvalid = 0, wvalid = 0, wlast = 0, bready = 0;
  logic [3:0]  arid = 0, awid = 0;
  logic [7:0]  arlen = 0;
  logic        arready, rvalid, rlast, awready, wready, bvalid;
  logic [3:0]  rid, bid;
  logic [31:0] rdata;
  logic [1:0]  rresp, bresp;

  dec_err_target u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_arvalid(arvalid), .s_arready(arready), .s_arid(arid), .s_arlen(arlen),
    .s_rvalid(rvalid), .s_rready(rready), .s_rid(rid), .s_rdata(rdata),
    .s_rresp(rresp), .s_rlast(rlast),
    .s_awvalid(awvalid), .s_awready(awready), .s_awid(awid),
    .s_wvalid(wvalid), .s_wready(wready), .s_wlast(wlast),
    .s_bvalid(bvalid), .s_bready(bready), .s_bid(bid), .s_bresp(bresp)
  );

  // Second instance built for a lite bus.
  logic        l_arvalid = 0, l_rready = 0;
  logic [7:0]  l_arlen = 0;
  logic [3:0]  l_arid = 0;
  logic        l_arready, l_rvalid, l_rlast, l_awready, l_wready, l_bvalid;
  logic [3:0]  l_rid, l_bid;
  logic [31:0] l_rdata;
  logic [1:0]  l_rresp, l_bresp;

  dec_err_target #(.LITE(1'b1)) u_dut_lite (
    .clk(clk), .rst_n(rst_n),
    .s_arvalid(l_arvalid), .s_arready(l_arready), .s_arid(l_arid), .s_arlen(l_arlen),
    .s_rvalid(l_rvalid), .s_rready(l_rready), .s_rid(l_rid), .s_rdata(l_rdata),
    .s_rresp(l_rresp), .s_rlast(l_rlast),
    .s_awvalid(1'b0), .s_awready(l_awready), .s_awid(4'd0),
    .s_wvalid(1'b0), .s_wready(l_wready), .s_wlast(1'b0),
    .s_bvalid(l_bvalid), .s_bready(1'b0), .s_bid(l_bid), .s_bresp(l_bresp)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model: queue of expected R beats, queue of pending AW ids,
  // count of completed W bursts awaiting their response.
  logic [4:0] rq[$];
  logic [3:0] awq[$];
  int  wl_cnt = 0;
  bit  m_ar_hs = 0, m_aw_hs = 0, m_w_hs = 0;
  int  coinc = 0, long_bursts = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      rq.delete(); awq.delete(); wl_cnt = 0;
      m_ar_hs = 0; m_aw_hs = 0; m_w_hs = 0;
    end else begin
      bit r_hs, b_hs, rl_hs;
      m_ar_hs = arvalid && (rq.size() == 0);
      r_hs    = (rq.size() > 0) && rready;
      rl_hs   = r_hs && rq[0][4];
      m_aw_hs = awvalid && (awq.size() == 0);
      m_w_hs  = wvalid && (wl_cnt == 0);
      b_hs    = (awq.size() > 0) && (wl_cnt > 0) && bready;
      if (rl_hs && b_hs) coinc++;
      if (r_hs) void'(rq.pop_front());
      if (m_ar_hs) begin
        if (arlen == 8'd255) long_bursts++;
        for (int i = 0; i <= int'(arlen); i++)
          rq.push_back({(i == int'(arlen)), arid});
      end
      if (b_hs) begin void'(awq.pop_front()); wl_cnt--; end
      if (m_aw_hs) awq.push_back(awid);
      if (m_w_hs && wlast) wl_cnt++;
    end
  end

  bit run = 0;
  int cyc = 0, wleft = 0;
  bit p_rv = 0, p_rr = 0, p_rl = 0, p_bv = 0, p_br = 0;
  logic [3:0] p_rid = 0, p_bid = 0;

  function automatic bit pick_ready(int c);
    case ((c / 2000) % 3)
      0:       return 1'b1;
      1:       return ($urandom % 2) == 0;
      default: return ($urandom % 4) == 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && run) begin
      bit e_rv, e_bv;
      e_rv = rq.size() > 0;
      e_bv = (awq.size() > 0) && (wl_cnt > 0);
      chk(arready == !e_rv, "R1", "arready", arready, !e_rv);
      chk(rvalid == e_rv, "R2", "rvalid", rvalid, e_rv);
      if (e_rv) begin
        chk(rlast == rq[0][4], "R2", "rlast", rlast, rq[0][4]);
        chk(rid == rq[0][3:0], "R3", "rid", rid, rq[0][3:0]);
        chk(rdata == 32'd0, "R3", "rdata", rdata, 0);
        chk(rresp == 2'b11, "R3", "rresp", rresp, 3);
      end
      chk(wready == (wl_cnt == 0), "R6", "wready", wready, wl_cnt == 0);
      chk(awready == (awq.size() == 0), "R8", "awready", awready, awq.size() == 0);
      chk(bvalid == e_bv, "R7", "bvalid", bvalid, e_bv);
      if (e_bv) begin
        chk(bid == awq[0], "R7", "bid", bid, awq[0]);
        chk(bresp == 2'b11, "R7", "bresp", bresp, 3);
      end
      if (p_rv && !p_rr)
        chk(rvalid && rid == p_rid && rlast == p_rl, "R4", "R hold", {rvalid, rid, rlast},
            {1'b1, p_rid, p_rl});
      if (p_bv && !p_br)
        chk(bvalid && bid == p_bid, "R8", "B hold", {bvalid, bid}, {1'b1, p_bid});

      // Drive next stimulus.
      cyc++;
      if (!arvalid || m_ar_hs) begin
        int r;
        r = $urandom % 16;
        arvalid = ($urandom % 3) == 0;
        arid    = 4'($urandom);
        arlen   = (r == 0) ? 8'd0 : (r == 1 && ($urandom % 4) == 0) ? 8'd255 : 8'($urandom % 12);
      end
      if (!awvalid || m_aw_hs) begin
        awvalid = ($urandom % 3) == 0;
        awid    = 4'($urandom);
      end
      if (!wvalid || m_w_hs) begin
        wvalid = ($urandom % 2) == 0;
        if (wvalid) begin
          if (wleft == 0) wleft = int'($urandom % 6) + 1;
          wleft--;
          wlast = (wleft == 0);
        end
      end
      rready = pick_ready(cyc);
      bready = pick_ready(cyc + 700);
      p_rv = rvalid; p_rr = rready; p_rid = rid; p_rl = rlast;
      p_bv = bvalid; p_br = bready; p_bid = bid;
    end
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state (R1, R6)
    chk(arready && awready && wready, "R1", "reset readies", {arready, awready, wready}, 7);
    chk(!rvalid && !bvalid, "R1", "reset valids", {rvalid, bvalid}, 0);
    chk(l_arready && !l_rvalid, "R1", "lite reset", {l_arready, l_rvalid}, 2);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: lite instance, long length field still gives one beat.
    begin
      int beats, lasts;
      beats = 0; lasts = 0;
      l_arvalid = 1; l_arlen = 8'd5; l_arid = 4'd9; l_rready = 1;
      @(negedge clk);
      l_arvalid = 0;
      for (int i = 0; i < 10; i++) begin
        if (l_rvalid) begin
          beats++;
          if (l_rlast) lasts++;
          chk(l_rresp == 2'b11 && l_rid == 4'd9, "R5", "lite beat payload",
              {l_rid, l_rresp}, {4'd9, 2'b11});
        end
        @(negedge clk);
      end
      chk(beats == 1, "R5", "lite beat count", beats, 1);
      chk(lasts == 1, "R5", "lite rlast count", lasts, 1);
    end

    run = 1;
    repeat (30000) @(negedge clk);
    run = 0;
    chk(coinc > 0, "R9", "same-edge read/write completions", coinc, 1);
    chk(long_bursts > 0, "R2", "256-beat bursts issued", long_bursts, 1);
    finish_run();
  end
endmodule